// File: doc/BRIEF.md
# Integer Carry and Overflow Flag Unit

This block derives the status flags of a 64-bit integer operation from the operands that went in and the result that came out. The result itself is computed elsewhere. It works out unsigned carry and signed overflow twice: once over the full 64-bit word and once over the low 32 bits of the same operands and result. It keeps a sticky summary-overflow bit and forms a 4-bit signed-compare record field from the result.

The operand set is operand A (bitwise inverted when the inversion control is set), operand B when it is marked valid, and an immediate when it is marked valid. Carry is set when any operand in the set, read as unsigned, is larger than the result. Overflow compares the signs of the first two operands in the set with the sign of the result. All flags are held in registers that load on a commit strobe. Separate enables decide which flag groups a given instruction writes. A 2-bit skip mask stops the carry writes for instructions that have already written a carry bit themselves.

Top module: `intflag_unit`

## Requirements
- R1: A synchronous reset clears every flag output, including all four record bits, to 0 at the next rising edge.
- R2: When commit is low at a rising edge, no output changes. When commit is high, the outputs show the new flags from the next edge on.
- R3: The operand set is A (or ~A when inv_a is 1), then src_b when src_b_vld is 1, then imm_val when imm_vld is 1. The 64-bit carry is 1 when any member of the set, as unsigned, is greater than the result.
- R4: The 32-bit carry applies the R3 rule to bits 31:0 of every operand and of the result.
- R5: The carry flags load only when carry_en is 1. carry_skip bit 0 blocks the 64-bit carry write and carry_skip bit 1 blocks the 32-bit carry write, each independently.
- R6: The 64-bit overflow is 1 when the first two members of the operand set have equal bit 63 and the result's bit 63 differs. The 32-bit overflow applies the same test to bit 31.
- R7: The overflow flags load only when ovf_en and ovf_vld are both 1 and the operand set has at least two members. Otherwise both hold.
- R8: On an overflow write, sticky_o becomes its old value ORed with the new 64-bit overflow. Nothing but reset clears it.
- R9: When rec_en is 1, rec_o loads {negative, positive, zero, summary} with negative in bit 3 and summary in bit 0. The summary bit is the value sticky_o takes in that same commit.
- R10: When rec_en is 0, rec_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| commit | input | 1 | Load enable for all flag registers |
| inv_a | input | 1 | Use bitwise inverse of src_a |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| src_b_vld | input | 1 | src_b takes part in the operand set |
| imm_val | input | 64 | Immediate operand |
| imm_vld | input | 1 | imm_val takes part in the operand set |
| result | input | 64 | Result of the operation |
| carry_en | input | 1 | Instruction writes carry flags |
| carry_skip | input | 2 | Bit 0 blocks 64-bit carry, bit 1 blocks 32-bit carry |
| ovf_en | input | 1 | Instruction requests overflow flags |
| ovf_vld | input | 1 | Overflow request is valid |
| rec_en | input | 1 | Instruction writes the record field |
| carry_o | output | 1 | 64-bit carry flag |
| carry32_o | output | 1 | 32-bit carry flag |
| ovf_o | output | 1 | 64-bit overflow flag |
| ovf32_o | output | 1 | 32-bit overflow flag |
| sticky_o | output | 1 | Sticky summary overflow |
| rec_o | output | 4 | Record field {neg, pos, zero, summary} |

## Verification
On every cycle the assertions check the write gating: the registers hold without commit, each carry bit holds when it is not enabled or is skipped, and the overflow pair and record field hold when they are not written. They also check that the summary bit never falls, that a set overflow implies a set summary, and that a written record field has exactly one sign bit set and a summary bit matching the register. The numeric values are shown only by the bench's scenarios, run against a reference model. These are carry and overflow at both widths, operand inversion, the immediate or second operand taking the pair position, and the sign class of the result.

// File: rtl/intflag_pkg.sv
`timescale 1ns/1ps
package intflag_pkg;
    localparam int REC_W   = 4;
    localparam int REC_NEG = 3;
    localparam int REC_POS = 2;
    localparam int REC_ZER = 1;
    localparam int REC_SUM = 0;

    typedef struct packed {
        logic             ca;
        logic             ca32;
        logic             ov;
        logic             ov32;
        logic             so;
        logic [REC_W-1:0] rec;
    } flag_state_t;
endpackage

// File: rtl/carry_detect.sv
`timescale 1ns/1ps
module carry_detect #(
    parameter int W     = 64,
    parameter int LOW_W = 32,
    parameter int N_OPS = 3
) (
    input  logic [N_OPS-1:0][W-1:0] ops,
    input  logic [N_OPS-1:0]        op_vld,
    input  logic [W-1:0]            res,
    output logic                    cy_full,
    output logic                    cy_low
);
    logic [N_OPS-1:0] gt_full;
    logic [N_OPS-1:0] gt_low;

    // One unsigned compare per operand and per view.
    for (genvar i = 0; i < N_OPS; i++) begin : g_cmp
        assign gt_full[i] = op_vld[i] && (ops[i] > res);
        assign gt_low[i]  = op_vld[i] && (ops[i][LOW_W-1:0] > res[LOW_W-1:0]);
    end

    assign cy_full = |gt_full;
    assign cy_low  = |gt_low;
endmodule

// File: rtl/ovf_detect.sv
`timescale 1ns/1ps
module ovf_detect #(
    parameter int N_VIEWS = 2
) (
    input  logic [N_VIEWS-1:0] x_sgn,
    input  logic [N_VIEWS-1:0] y_sgn,
    input  logic [N_VIEWS-1:0] r_sgn,
    output logic [N_VIEWS-1:0] ov
);
    // Operands agree in sign and the result disagrees.
    for (genvar v = 0; v < N_VIEWS; v++) begin : g_view
        assign ov[v] = (x_sgn[v] ~^ y_sgn[v]) & (r_sgn[v] ^ x_sgn[v]);
    end
endmodule

// File: rtl/record_form.sv
`timescale 1ns/1ps
module record_form
    import intflag_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]     res,
    input  logic             so_in,
    output logic [REC_W-1:0] rec
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = res[W-1];
    assign is_zero = ~|res;

    always_comb begin
        rec          = '0;
        rec[REC_NEG] = is_neg;
        rec[REC_POS] = ~is_neg & ~is_zero;
        rec[REC_ZER] = is_zero;
        rec[REC_SUM] = so_in;
    end
endmodule

// File: rtl/intflag_unit.sv
`timescale 1ns/1ps
module intflag_unit
    import intflag_pkg::*;
#(
    parameter int W     = 64,
    parameter int LOW_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic             inv_a,
    input  logic [W-1:0]     src_a,
    input  logic [W-1:0]     src_b,
    input  logic             src_b_vld,
    input  logic [W-1:0]     imm_val,
    input  logic             imm_vld,
    input  logic [W-1:0]     result,
    input  logic             carry_en,
    input  logic [1:0]       carry_skip,
    input  logic             ovf_en,
    input  logic             ovf_vld,
    input  logic             rec_en,
    output logic             carry_o,
    output logic             carry32_o,
    output logic             ovf_o,
    output logic             ovf32_o,
    output logic             sticky_o,
    output logic [REC_W-1:0] rec_o
);
    localparam int N_OPS   = 3;
    localparam int N_VIEWS = 2;
    localparam int V_FULL  = 0;
    localparam int V_LOW   = 1;

    flag_state_t state_q;
    flag_state_t nxt_d;

    logic [W-1:0]              a_eff;
    logic [W-1:0]              pair_b;
    logic                      pair_ok;
    logic [N_OPS-1:0][W-1:0]   op_list;
    logic [N_OPS-1:0]          op_vld;
    logic                      cy_full;
    logic                      cy_low;
    logic [N_VIEWS-1:0]        x_sgn;
    logic [N_VIEWS-1:0]        y_sgn;
    logic [N_VIEWS-1:0]        r_sgn;
    logic [N_VIEWS-1:0]        ov_vec;
    logic                      ov_wr;
    logic                      so_new;
    logic [REC_W-1:0]          rec_new;

    // Operand set: inverted-or-plain A, then B, then the immediate.
    assign a_eff   = inv_a ? ~src_a : src_a;
    assign op_list = {imm_val, src_b, a_eff};
    assign op_vld  = {imm_vld, src_b_vld, 1'b1};

    // Second member of the set is B if present, else the immediate.
    assign pair_b  = src_b_vld ? src_b : imm_val;
    assign pair_ok = src_b_vld | imm_vld;

    carry_detect #(.W(W), .LOW_W(LOW_W), .N_OPS(N_OPS)) u_carry (
        .ops     (op_list),
        .op_vld  (op_vld),
        .res     (result),
        .cy_full (cy_full),
        .cy_low  (cy_low)
    );

    assign x_sgn[V_FULL] = a_eff[W-1];
    assign x_sgn[V_LOW]  = a_eff[LOW_W-1];
    assign y_sgn[V_FULL] = pair_b[W-1];
    assign y_sgn[V_LOW]  = pair_b[LOW_W-1];
    assign r_sgn[V_FULL] = result[W-1];
    assign r_sgn[V_LOW]  = result[LOW_W-1];

    ovf_detect #(.N_VIEWS(N_VIEWS)) u_ovf (
        .x_sgn (x_sgn),
        .y_sgn (y_sgn),
        .r_sgn (r_sgn),
        .ov    (ov_vec)
    );

    assign ov_wr  = ovf_en & ovf_vld & pair_ok;
    assign so_new = state_q.so | (ov_wr & ov_vec[V_FULL]);

    record_form #(.W(W)) u_rec (
        .res   (result),
        .so_in (so_new),
        .rec   (rec_new)
    );

    always_comb begin
        nxt_d = state_q;
        if (carry_en && !carry_skip[0]) nxt_d.ca   = cy_full;
        if (carry_en && !carry_skip[1]) nxt_d.ca32 = cy_low;
        if (ov_wr) begin
            nxt_d.ov   = ov_vec[V_FULL];
            nxt_d.ov32 = ov_vec[V_LOW];
        end
        nxt_d.so = so_new;
        if (rec_en) nxt_d.rec = rec_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (commit) begin
            state_q <= nxt_d;
        end
    end

    assign carry_o   = state_q.ca;
    assign carry32_o = state_q.ca32;
    assign ovf_o     = state_q.ov;
    assign ovf32_o   = state_q.ov32;
    assign sticky_o  = state_q.so;
    assign rec_o     = state_q.rec;
endmodule

// File: rtl/intflag_unit_chk.sv
`timescale 1ns/1ps
module intflag_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       commit,
    input logic       carry_en,
    input logic [1:0] carry_skip,
    input logic       ovf_en,
    input logic       ovf_vld,
    input logic       rec_en,
    input logic       carry_o,
    input logic       carry32_o,
    input logic       ovf_o,
    input logic       ovf32_o,
    input logic       sticky_o,
    input logic [3:0] rec_o
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> ({carry_o, carry32_o, ovf_o, ovf32_o, sticky_o, rec_o} == 9'd0));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable({carry_o, carry32_o, ovf_o, ovf32_o, sticky_o, rec_o}));

    assert_carry_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !(commit && carry_en && !carry_skip[0]) |=> $stable(carry_o));

    assert_carry32_gate_R5: assert property (@(posedge clk) disable iff (rst)
        !(commit && carry_en && !carry_skip[1]) |=> $stable(carry32_o));

    assert_ovf_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !(commit && ovf_en && ovf_vld) |=> $stable({ovf_o, ovf32_o, sticky_o}));

    assert_sticky_keep_R8: assert property (@(posedge clk) disable iff (rst)
        sticky_o |=> sticky_o);

    assert_sticky_cover_R8: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> sticky_o);

    assert_record_shape_R9: assert property (@(posedge clk) disable iff (rst)
        (commit && rec_en) |=> (rec_o[0] == sticky_o) && ($countones(rec_o[3:1]) == 1));

    assert_record_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(commit && rec_en) |=> $stable(rec_o));
endmodule

bind intflag_unit intflag_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .commit     (commit),
    .carry_en   (carry_en),
    .carry_skip (carry_skip),
    .ovf_en     (ovf_en),
    .ovf_vld    (ovf_vld),
    .rec_en     (rec_en),
    .carry_o    (carry_o),
    .carry32_o  (carry32_o),
    .ovf_o      (ovf_o),
    .ovf32_o    (ovf32_o),
    .sticky_o   (sticky_o),
    .rec_o      (rec_o)
);

// File: tb/test_intflag_unit.sv
`timescale 1ns/1ps
module test_intflag_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        commit = 1'b0;
    logic        inv_a = 1'b0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        src_b_vld = 1'b0;
    logic [63:0] imm_val = '0;
    logic        imm_vld = 1'b0;
    logic [63:0] result = '0;
    logic        carry_en = 1'b0;
    logic [1:0]  carry_skip = 2'b00;
    logic        ovf_en = 1'b0;
    logic        ovf_vld = 1'b0;
    logic        rec_en = 1'b0;
    logic        carry_o, carry32_o, ovf_o, ovf32_o, sticky_o;
    logic [3:0]  rec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic m_ca, m_ca32, m_ov, m_ov32, m_so;
    logic [3:0] m_rec;

    always #4 clk = ~clk;

    intflag_unit i_intflag_unit (
        .clk(clk), .rst(rst), .commit(commit), .inv_a(inv_a),
        .src_a(src_a), .src_b(src_b), .src_b_vld(src_b_vld),
        .imm_val(imm_val), .imm_vld(imm_vld), .result(result),
        .carry_en(carry_en), .carry_skip(carry_skip),
        .ovf_en(ovf_en), .ovf_vld(ovf_vld), .rec_en(rec_en),
        .carry_o(carry_o), .carry32_o(carry32_o), .ovf_o(ovf_o),
        .ovf32_o(ovf32_o), .sticky_o(sticky_o), .rec_o(rec_o)
    );

    function automatic logic gt_of(logic [63:0] x, logic [63:0] r, bit low);
        return low ? (x[31:0] > r[31:0]) : (x > r);
    endfunction

    function automatic logic ov_of(logic [63:0] x, logic [63:0] y, logic [63:0] r, bit low);
        int s = low ? 31 : 63;
        return (x[s] == y[s]) && (r[s] != x[s]);
    endfunction

    function automatic logic [63:0] rnd64();
        logic [63:0] v = {$urandom, $urandom};
        case ($urandom % 6)
            0: v = 64'h7FFF_FFFF_FFFF_FFFF ^ {63'd0, v[0]};
            1: v = 64'h0000_0000_7FFF_FFFF + {62'd0, v[1:0]};
            2: v = '0;
            default: ;
        endcase
        return v;
    endfunction

    task automatic chk(string tag, string ctx, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s) actual=%h expected=%h", tag, ctx, act, exp);
        end
    endtask

    task automatic check_all(string ctx);
        chk("R3", ctx, {3'd0, carry_o},   {3'd0, m_ca});
        chk("R4", ctx, {3'd0, carry32_o}, {3'd0, m_ca32});
        chk("R6", ctx, {3'd0, ovf_o},     {3'd0, m_ov});
        chk("R6", ctx, {3'd0, ovf32_o},   {3'd0, m_ov32});
        chk("R8", ctx, {3'd0, sticky_o},  {3'd0, m_so});
        chk("R9", ctx, rec_o, m_rec);
    endtask

    // Apply one operation, update the model, sample after the edge.
    task automatic step(input logic com, input logic inv, input logic [63:0] a,
                        input logic [63:0] b, input logic bv, input logic [63:0] im,
                        input logic iv, input logic [63:0] res, input logic cen,
                        input logic [1:0] skp, input logic oen, input logic ovv,
                        input logic ren, input string ctx);
        logic [63:0] ae, y;
        @(negedge clk);
        commit = com; inv_a = inv; src_a = a; src_b = b; src_b_vld = bv;
        imm_val = im; imm_vld = iv; result = res; carry_en = cen;
        carry_skip = skp; ovf_en = oen; ovf_vld = ovv; rec_en = ren;
        ae = inv ? ~a : a;
        y  = bv ? b : im;
        if (com) begin
            if (cen && !skp[0])
                m_ca = gt_of(ae, res, 0) | (bv & gt_of(b, res, 0)) | (iv & gt_of(im, res, 0));
            if (cen && !skp[1])
                m_ca32 = gt_of(ae, res, 1) | (bv & gt_of(b, res, 1)) | (iv & gt_of(im, res, 1));
            if (oen && ovv && (bv || iv)) begin
                m_ov   = ov_of(ae, y, res, 0);
                m_ov32 = ov_of(ae, y, res, 1);
                m_so   = m_so | m_ov;
            end
            if (ren)
                m_rec = {res[63], !res[63] && (res != 0), res == 0, m_so};
        end
        @(posedge clk);
        #1;
        check_all(ctx);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        commit = 1'b1; carry_en = 1'b1; ovf_en = 1'b1; ovf_vld = 1'b1; rec_en = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0; commit = 1'b0;
        {m_ca, m_ca32, m_ov, m_ov32, m_so} = '0;
        m_rec = '0;
        check_all("R1 reset");
    endtask

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        {m_ca, m_ca32, m_ov, m_ov32, m_so} = '0;
        m_rec = '0;
        repeat (2) @(posedge clk);
        do_reset();

        // R3: 64-bit wrap sets carry; low half does not wrap
        step(1, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0000, 1, '0, 0,
             64'h0000_0000_0000_0001, 1, 2'b00, 0, 0, 0, "R3 full wrap");
        // R4: only the low 32 bits wrap
        step(1, 0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0002, 1, '0, 0,
             64'h0000_0001_0000_0001, 1, 2'b00, 0, 0, 0, "R4 low wrap");
        // R5: skip mask bit 0 keeps 64-bit carry, bit 1 keeps 32-bit carry
        step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1, '0, 0, 64'h0, 1, 2'b01,
             0, 0, 0, "R5 skip low bit");
        step(1, 0, 64'h0, 64'h0, 1, '0, 0, 64'h5, 1, 2'b10, 0, 0, 0, "R5 skip high bit");
        step(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1, '0, 0, 64'h0, 0, 2'b00,
             0, 0, 0, "R5 carry disabled");
        // R3: inverted A with immediate only
        step(1, 1, 64'h0, 64'h0, 0, 64'h3, 1, 64'h2, 1, 2'b00, 0, 0, 0, "R3 inverted A");
        // R6: signed overflow at 64 bits, sticky and record in same commit (R9)
        step(1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 1, '0, 0, 64'h8000_0000_0000_0000,
             1, 2'b00, 1, 1, 1, "R6 R9 full overflow");
        // R8: next non-overflowing write clears ovf but not sticky
        step(1, 0, 64'h1, 64'h1, 1, '0, 0, 64'h2, 0, 2'b00, 1, 1, 1, "R8 sticky kept");
        // R6: 32-bit overflow only, immediate as second operand
        step(1, 0, 64'h7FFF_FFFF, 64'hDEAD, 0, 64'h1, 1, 64'h8000_0000, 0, 2'b00,
             1, 1, 0, "R6 low overflow via imm");
        // R7: single operand, overflow request ignored
        step(1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 0, '0, 0,
             64'h8000_0000_0000_0000, 0, 2'b00, 1, 1, 0, "R7 one operand");
        // R7: ovf_vld low, no overflow write
        step(1, 0, 64'h0, 64'h0, 1, '0, 0, 64'h8000_0000_8000_0000, 0, 2'b00,
             1, 0, 0, "R7 not valid");
        // R10: record not enabled holds previous field
        step(1, 0, 64'h0, 64'h0, 1, '0, 0, 64'h0, 0, 2'b00, 0, 0, 0, "R10 record held");
        // R9: zero and negative results
        step(1, 0, 64'h0, 64'h0, 1, '0, 0, 64'h0, 0, 2'b00, 0, 0, 1, "R9 zero");
        step(1, 0, 64'h0, 64'h0, 1, '0, 0, 64'hF000_0000_0000_0000, 0, 2'b00, 0, 0, 1,
             "R9 negative");
        // R2: everything enabled but no commit
        step(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, 1, 64'h1, 1, 64'h5,
             1, 2'b00, 1, 1, 1, "R2 no commit");
        // R1: reset in the middle clears sticky too
        do_reset();

        for (int n = 0; n < 600; n++) begin
            logic [63:0] a = rnd64();
            logic [63:0] b = rnd64();
            logic [63:0] im = rnd64();
            logic bv = ($urandom % 4) != 0;
            logic iv = ($urandom % 3) == 0;
            logic inv = ($urandom % 4) == 0;
            logic [63:0] ae = inv ? ~a : a;
            logic [63:0] res;
            case ($urandom % 4)
                0, 1: res = ae + (bv ? b : 64'd0) + (iv ? im : 64'd0);
                2: res = rnd64();
                default: res = {$urandom, $urandom};
            endcase
            step(($urandom % 8) != 0, inv, a, b, bv, im, iv, res,
                 ($urandom % 3) != 0, 2'($urandom), ($urandom % 3) != 0,
                 ($urandom % 4) != 0, ($urandom % 2) == 0, "random");
            if (n == 300) do_reset();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule